// File: doc/BRIEF.md
# Segmented Indexed-Element Operand Stage

This block prepares the three operand vectors for a vector multiply-subtract in which the second factor is one element picked by an immediate index. It accepts a multiplicand vector, an indexed-source vector, an accumulator vector and a decoded 32-bit instruction word. From the word it extracts the lane size and the immediate index. It then registers three lane buses for the arithmetic stage that follows:

- the accumulator, passed through unchanged;
- the multiplicand with every lane's sign bit inverted;
- the indexed source, where each lane carries the chosen element of its own 128-bit segment.

The vector width `VLEN` is a parameter and must be a multiple of 128. Each 128-bit segment is handled on its own. Lane k of segment j receives element `idx` of segment j. Nothing is predicated, so every lane is always driven. A two-bit lane-size tag goes out with the buses so that the downstream arithmetic knows how to split them.

Top module: `vix_operand_stage`

## Requirements
- R1: The lane size is decoded from word bits 23:22. The value 10 gives 32-bit lanes and 11 gives 64-bit lanes. Any other value gives 16-bit lanes. The tag `out_lsz` encodes 16-bit lanes as 00, 32-bit as 01 and 64-bit as 10, and it never shows 11.
- R2: With 16-bit lanes, the 3-bit index is {bit 22, bit 20, bit 19} of the word, with bit 22 as the most significant bit. It selects one of 8 elements per segment.
- R3: With 32-bit lanes, the index is word bits 20:19. It selects one of 4 elements per segment.
- R4: With 64-bit lanes, the index is word bit 20. It selects one of 2 elements per segment.
- R5: Every lane of `out_bcast` inside a 128-bit segment holds the same value. That value is the element at position `idx` within that segment of `idx_vec`, where element 0 occupies the lowest bits.
- R6: Segments are independent. Segment j of `out_bcast` depends only on segment j of `idx_vec`.
- R7: In `out_negmul`, each lane equals the matching `mul_vec` lane with only its most significant (sign) bit inverted. All other bits, including NaN payloads, are unchanged.
- R8: `out_acc` equals `acc_vec`.
- R9: All outputs are registered and reflect the inputs one clock edge later. While `rst_n` is low, every output reads zero and the tag reads 00.
- R10: Word bits other than 23:22, 20 and 19 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_word | input | 32 | Decoded instruction word |
| mul_vec | input | VLEN | Multiplicand vector |
| idx_vec | input | VLEN | Source of the indexed element |
| acc_vec | input | VLEN | Accumulator vector |
| out_acc | output | VLEN | Registered accumulator lanes |
| out_negmul | output | VLEN | Registered sign-inverted multiplicand lanes |
| out_bcast | output | VLEN | Registered per-segment broadcast lanes |
| out_lsz | output | 2 | Registered lane-size tag |

## Verification
Every output, including the tag, is due exactly one rising edge after its inputs are applied. No output has a longer or data-dependent path.

The bench drives each stimulus on a falling edge and reads all four outputs on the next falling edge. At that point the single capturing edge has passed and the next stimulus has not yet been applied.

Each stimulus is then replaced before the following edge, so a result that arrives late or early shows up as a mismatch against the value computed for that stimulus.

// File: rtl/vix_pkg.sv
package vix_pkg;

   localparam int unsigned SEG_BITS = 128;

   typedef enum logic [1:0] {
      LSZ_H = 2'b00,
      LSZ_S = 2'b01,
      LSZ_D = 2'b10
   } lsz_e;

   typedef struct packed {
      lsz_e       lsz;
      logic [2:0] idx;
   } sel_t;

   function automatic int unsigned lsz_bits(input lsz_e l);
      case (l)
         LSZ_S:   return 32;
         LSZ_D:   return 64;
         default: return 16;
      endcase
   endfunction

endpackage

// File: rtl/vix_decode.sv
module vix_decode
   import vix_pkg::*;
#(
   parameter int unsigned SZ_HI  = 23,
   parameter int unsigned SZ_LO  = 22,
   parameter int unsigned IDX_HI = 20,
   parameter int unsigned IDX_LO = 19
) (
   input  logic [31:0] word,
   output sel_t        sel
);

   initial begin : chk_params
      if (SZ_HI != SZ_LO + 1 || IDX_HI != IDX_LO + 1 || SZ_HI > 31)
         $fatal(1, "vix_decode: field positions must be adjacent pairs");
   end

   wire unused_word = ^word;

   always_comb begin
      sel = '0;
      unique case ({word[SZ_HI], word[SZ_LO]})
         2'b10: begin
            sel.lsz = LSZ_S;
            sel.idx = {1'b0, word[IDX_HI], word[IDX_LO]};
         end
         2'b11: begin
            sel.lsz = LSZ_D;
            sel.idx = {2'b00, word[IDX_HI]};
         end
         default: begin
            sel.lsz = LSZ_H;
            sel.idx = {word[SZ_LO], word[IDX_HI], word[IDX_LO]};
         end
      endcase
   end

endmodule

// File: rtl/vix_seg_bcast.sv
module vix_seg_bcast
   import vix_pkg::*;
#(
   parameter int unsigned ESIZE = 16
) (
   input  logic [SEG_BITS-1:0] seg,
   input  logic [2:0]          idx,
   output logic [SEG_BITS-1:0] rep
);

   localparam int unsigned EPS  = SEG_BITS / ESIZE;
   localparam int unsigned IDXW = $clog2(EPS);

   initial begin : chk_params
      if (ESIZE != 16 && ESIZE != 32 && ESIZE != 64)
         $fatal(1, "vix_seg_bcast: ESIZE must be 16, 32 or 64");
   end

   wire unused_idx = ^idx;

   logic [ESIZE-1:0] pick;

   assign pick = seg[idx[IDXW-1:0]*ESIZE +: ESIZE];
   assign rep  = {EPS{pick}};

endmodule

// File: rtl/vix_sign_flip.sv
module vix_sign_flip #(
   parameter int unsigned W     = 256,
   parameter int unsigned ESIZE = 16
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   localparam int unsigned LANES = W / ESIZE;

   initial begin : chk_params
      if (W % ESIZE != 0)
         $fatal(1, "vix_sign_flip: W must be a multiple of ESIZE");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign dout[l*ESIZE +: ESIZE] =
         {~din[l*ESIZE + ESIZE - 1], din[l*ESIZE +: ESIZE-1]};
   end

endmodule

// File: rtl/vix_operand_stage.sv
module vix_operand_stage
   import vix_pkg::*;
#(
   parameter int unsigned VLEN = 256
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [31:0]     insn_word,
   input  logic [VLEN-1:0] mul_vec,
   input  logic [VLEN-1:0] idx_vec,
   input  logic [VLEN-1:0] acc_vec,
   output logic [VLEN-1:0] out_acc,
   output logic [VLEN-1:0] out_negmul,
   output logic [VLEN-1:0] out_bcast,
   output logic [1:0]      out_lsz
);

   localparam int unsigned NSEG = VLEN / SEG_BITS;

   initial begin : chk_params
      if (VLEN < SEG_BITS || VLEN % SEG_BITS != 0)
         $fatal(1, "vix_operand_stage: VLEN must be a nonzero multiple of 128");
   end

   sel_t sel;

   vix_decode u_dec (
      .word (insn_word),
      .sel  (sel)
   );

   logic [VLEN-1:0] rep_h, rep_s, rep_d;
   logic [VLEN-1:0] neg_h, neg_s, neg_d;

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      vix_seg_bcast #(.ESIZE(16)) u_bh (
         .seg (idx_vec[s*SEG_BITS +: SEG_BITS]),
         .idx (sel.idx),
         .rep (rep_h[s*SEG_BITS +: SEG_BITS])
      );
      vix_seg_bcast #(.ESIZE(32)) u_bs (
         .seg (idx_vec[s*SEG_BITS +: SEG_BITS]),
         .idx (sel.idx),
         .rep (rep_s[s*SEG_BITS +: SEG_BITS])
      );
      vix_seg_bcast #(.ESIZE(64)) u_bd (
         .seg (idx_vec[s*SEG_BITS +: SEG_BITS]),
         .idx (sel.idx),
         .rep (rep_d[s*SEG_BITS +: SEG_BITS])
      );
   end

   vix_sign_flip #(.W(VLEN), .ESIZE(16)) u_nh (.din(mul_vec), .dout(neg_h));
   vix_sign_flip #(.W(VLEN), .ESIZE(32)) u_ns (.din(mul_vec), .dout(neg_s));
   vix_sign_flip #(.W(VLEN), .ESIZE(64)) u_nd (.din(mul_vec), .dout(neg_d));

   logic [VLEN-1:0] nxt_bcast, nxt_neg;

   always_comb begin
      unique case (sel.lsz)
         LSZ_S: begin
            nxt_bcast = rep_s;
            nxt_neg   = neg_s;
         end
         LSZ_D: begin
            nxt_bcast = rep_d;
            nxt_neg   = neg_d;
         end
         default: begin
            nxt_bcast = rep_h;
            nxt_neg   = neg_h;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_acc    <= '0;
         out_negmul <= '0;
         out_bcast  <= '0;
         out_lsz    <= LSZ_H;
      end else begin
         out_acc    <= acc_vec;
         out_negmul <= nxt_neg;
         out_bcast  <= nxt_bcast;
         out_lsz    <= sel.lsz;
      end
   end

endmodule

// File: rtl/vix_operand_stage_chk.sv
module vix_operand_stage_chk #(
   parameter int unsigned VLEN = 256
) (
   input logic            clk,
   input logic            rst_n,
   input logic [31:0]     insn_word,
   input logic [VLEN-1:0] mul_vec,
   input logic [VLEN-1:0] acc_vec,
   input logic [VLEN-1:0] out_acc,
   input logic [VLEN-1:0] out_negmul,
   input logic [VLEN-1:0] out_bcast,
   input logic [1:0]      out_lsz
);

   localparam int unsigned NSEG = VLEN / 128;

   wire unused_chk = ^{insn_word[31:24], insn_word[21:0]};

   logic [VLEN-1:0] sgn16;
   for (genvar l = 0; l < VLEN / 16; l++) begin : g_mask
      assign sgn16[l*16 +: 16] = 16'h8000;
   end

   logic [VLEN-1:0] mul_q;
   always_ff @(posedge clk) mul_q <= mul_vec;

   logic [VLEN-1:0] flips;
   assign flips = out_negmul ^ mul_q;

   int exp_cnt;
   always_comb begin
      case (out_lsz)
         2'b00:   exp_cnt = VLEN / 16;
         2'b01:   exp_cnt = VLEN / 32;
         default: exp_cnt = VLEN / 64;
      endcase
   end

   p_acc_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> out_acc == $past(acc_vec));

   p_flip_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (flips & ~sgn16) == '0);

   p_flip_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $countones(flips) == exp_cnt);

   p_tag_s_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(insn_word[23:22]) == 2'b10) |-> out_lsz == 2'b01);

   p_tag_d_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(insn_word[23:22]) == 2'b11) |-> out_lsz == 2'b10);

   p_tag_h_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(insn_word[23])) |-> out_lsz == 2'b00);

   p_tag_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_lsz != 2'b11);

   for (genvar s = 0; s < NSEG; s++) begin : g_seg_chk
      p_seg_halves_r5: assert property (@(posedge clk) disable iff (!rst_n)
         out_bcast[s*128 +: 64] == out_bcast[s*128 + 64 +: 64]);
   end

endmodule

bind vix_operand_stage vix_operand_stage_chk #(.VLEN(VLEN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .insn_word  (insn_word),
   .mul_vec    (mul_vec),
   .acc_vec    (acc_vec),
   .out_acc    (out_acc),
   .out_negmul (out_negmul),
   .out_bcast  (out_bcast),
   .out_lsz    (out_lsz)
);

// File: tb/tb_vix_operand_stage.sv
`timescale 1ns/1ps
module tb_vix_operand_stage;

   localparam int VL = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   insn_word = '0;
   logic [VL-1:0] mul_vec = '0, idx_vec = '0, acc_vec = '0;
   logic [VL-1:0] out_acc, out_negmul, out_bcast;
   logic [1:0]    out_lsz;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   vix_operand_stage #(.VLEN(VL)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .insn_word  (insn_word),
      .mul_vec    (mul_vec),
      .idx_vec    (idx_vec),
      .acc_vec    (acc_vec),
      .out_acc    (out_acc),
      .out_negmul (out_negmul),
      .out_bcast  (out_bcast),
      .out_lsz    (out_lsz)
   );

   task automatic chk_vec(input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_tag(input string req, input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   function automatic logic [VL-1:0] rnd_vec();
      logic [VL-1:0] v;
      for (int k = 0; k < VL / 32; k++) v[k*32 +: 32] = $urandom;
      return v;
   endfunction

   // sz: 0 = 16-bit, 1 = 32-bit, 2 = 64-bit lanes
   function automatic logic [31:0] mk_word(input int sz, input int idx, input logic [31:0] noise);
      logic [31:0] w = noise;
      w[31:24] = 8'h64;
      case (sz)
         0: begin w[23] = 1'b0; w[22] = idx[2]; w[21] = 1'b0; w[20:19] = idx[1:0]; end
         1: begin w[23:22] = 2'b10; w[21] = 1'b1; w[20:19] = idx[1:0]; end
         default: begin w[23:22] = 2'b11; w[21] = 1'b1; w[20] = idx[0]; end
      endcase
      return w;
   endfunction

   function automatic logic [VL-1:0] exp_bcast(input int sz, input int idx, input logic [VL-1:0] v);
      logic [VL-1:0] r;
      int es  = 16 << sz;
      int eps = 128 / es;
      for (int e = 0; e < VL / es; e++) begin
         int src = e - (e % eps) + idx;
         for (int b = 0; b < es; b++) r[e*es + b] = v[src*es + b];
      end
      return r;
   endfunction

   function automatic logic [VL-1:0] exp_neg(input int sz, input logic [VL-1:0] v);
      logic [VL-1:0] r = v;
      int es = 16 << sz;
      for (int e = 0; e < VL / es; e++) r[e*es + es - 1] = ~v[e*es + es - 1];
      return r;
   endfunction

   function automatic logic [VL-1:0] pat_vec(input int p, input int salt);
      logic [VL-1:0] v;
      case (p)
         0: v = '1;
         1: for (int k = 0; k < VL / 8; k++) v[k*8 +: 8] = 8'(k + salt);
         default: v = rnd_vec();
      endcase
      return v;
   endfunction

   task automatic apply_and_check(input int sz, input int idx, input int p);
      logic [VL-1:0] m, x, a;
      logic [31:0]   w;
      string         rq;
      m = pat_vec(p, 3);
      x = pat_vec(p, 101);
      a = rnd_vec();
      w = mk_word(sz, idx, $urandom);
      rq = (sz == 0) ? "R2" : (sz == 1) ? "R3" : "R4";
      @(negedge clk);
      insn_word = w; mul_vec = m; idx_vec = x; acc_vec = a;
      @(negedge clk);
      chk_tag("R1 tag", out_lsz, 2'(sz));
      chk_vec({rq, " R5 R6 broadcast"}, out_bcast, exp_bcast(sz, idx, x));
      chk_vec("R7 sign invert", out_negmul, exp_neg(sz, m));
      chk_vec("R8 R9 accumulator", out_acc, a);
      // R10: a different set of don't-care word bits, same data
      w = mk_word(sz, idx, ~w);
      insn_word = w;
      @(negedge clk);
      chk_vec("R10 ignored bits broadcast", out_bcast, exp_bcast(sz, idx, x));
      chk_tag("R10 ignored bits tag", out_lsz, 2'(sz));
   endtask

   initial begin : watchdog
      #(150000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : stim
      mul_vec   = rnd_vec();
      idx_vec   = rnd_vec();
      acc_vec   = rnd_vec();
      insn_word = 32'h64A0_0000;
      repeat (3) @(negedge clk);
      chk_vec("R9 reset acc", out_acc, '0);
      chk_vec("R9 reset negmul", out_negmul, '0);
      chk_vec("R9 reset bcast", out_bcast, '0);
      chk_tag("R9 reset tag", out_lsz, 2'b00);
      rst_n = 1'b1;

      // latency: new data appears after one edge exactly
      acc_vec = {VL/32{32'hA5A5_5A5A}};
      @(negedge clk);
      chk_vec("R9 one-edge latency", out_acc, {VL/32{32'hA5A5_5A5A}});

      for (int sz = 0; sz < 3; sz++)
         for (int idx = 0; idx < (8 >> sz); idx++)
            for (int p = 0; p < 4; p++)
               apply_and_check(sz, idx, p);

      // R1: bit pattern 01 in 23:22 is 16-bit lanes with index msb set
      @(negedge clk);
      insn_word = 32'h6448_0000;
      idx_vec   = rnd_vec();
      @(negedge clk);
      chk_tag("R1 pattern 01 tag", out_lsz, 2'b00);
      chk_vec("R2 pattern 01 index 5", out_bcast, exp_bcast(0, 5, idx_vec));

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule